// File: doc/BRIEF.md
# Wishbone External Window Bridge

This block is a Wishbone slave that claims a fixed 128-byte window of the host address space and turns every access that lands in it into a strobed transfer on a simple peripheral port. A read raises a dedicated read strobe and returns the peripheral's data to the host. A write raises a dedicated write strobe and presents the host's data. In both cases the word offset inside the window appears on a 5-bit address bus.

The acknowledge back to the host is chosen at build time. In immediate mode the bridge acknowledges on its own, so each access takes a single strobe cycle. In relayed mode the host acknowledge follows the peripheral's acknowledge input, and the access can stretch over as many clocks as the peripheral needs.

The control path is a two-state machine. In `EAR_IDLE` the bridge watches for a request. The transition `T_ACCEPT` is taken when CYC and STB are both high and the address falls inside the window; it captures the offset, the write data and the direction. In `EAR_ACCESS` the strobe is driven. From that state the machine takes `T_FINISH` back to idle at the clock edge where the acknowledge is high, or `T_ABORT` at the edge where the host has dropped CYC or STB. Without either event it takes `T_HOLD` and stays. A request that misses the window is not accepted, so the machine stays in `EAR_IDLE` (`T_IGNORE`).

Top module: `wb_ear_bridge`

## Requirements
- R1: While reset is asserted and after its release with no request, `wb_ack_o`, `ext_rd_o` and `ext_wr_o` are low, and `ext_adr_o`, `ext_dat_o` and `wb_dat_o` are zero.
- R2: An access hits the window only when `wb_adr_i[31:7]` equals `BASE_ADDR[31:7]`. An access outside the window never raises `ext_rd_o`, `ext_wr_o` or `wb_ack_o`.
- R3: A hit with `wb_we_i` low raises `ext_rd_o` one clock after the request is first sampled, and `ext_wr_o` stays low. While `ext_rd_o` is high, `wb_dat_o` equals `ext_dat_i`; otherwise `wb_dat_o` is zero.
- R4: A hit with `wb_we_i` high raises `ext_wr_o` one clock after the request is first sampled, and `ext_rd_o` stays low. While `ext_wr_o` is high, `ext_dat_o` carries the `wb_dat_i` value sampled when the access was accepted.
- R5: While a strobe is high, `ext_adr_o` equals `wb_adr_i[6:2]` as sampled when the access was accepted, so the last word of the window gives offset 31.
- R6: While neither strobe is high, `ext_adr_o` and `ext_dat_o` are zero.
- R7: With `IMM_ACK` = 1, `wb_ack_o` is high in the first strobe cycle, and every strobe lasts exactly one clock.
- R8: With `IMM_ACK` = 0, `wb_ack_o` is high only while a strobe is high and `ext_ack_i` is high. Until then the strobe, `ext_adr_o` and `ext_dat_o` hold their values, even if `wb_adr_i` or `wb_dat_i` change.
- R9: After a clock edge with `wb_ack_o` high, both strobes are low. Both strobes are also low in any cycle where `wb_cyc_i` or `wb_stb_i` is low, and an access abandoned this way gives no acknowledge.
- R10: `ext_rd_o` and `ext_wr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Wishbone cycle valid |
| wb_stb_i | input | 1 | Wishbone strobe |
| wb_we_i | input | 1 | Wishbone write enable |
| wb_adr_i | input | 32 | Wishbone byte address |
| wb_dat_i | input | 32 | Wishbone write data |
| wb_dat_o | output | 32 | Wishbone read data |
| wb_ack_o | output | 1 | Wishbone acknowledge |
| ext_rd_o | output | 1 | Peripheral read strobe |
| ext_wr_o | output | 1 | Peripheral write strobe |
| ext_adr_o | output | 5 | Peripheral word offset |
| ext_dat_o | output | 32 | Peripheral write data |
| ext_dat_i | input | 32 | Peripheral read data |
| ext_ack_i | input | 1 | Peripheral acknowledge for relayed mode |

## Verification
The assertions assume that the host keeps `wb_adr_i` steady from the request until the strobe rises. The window check compares the address of the accepting edge with the moment the strobe appears. They also assume that `ext_ack_i` is only counted while a strobe is active. The stimulus presents each request, with its address, at a single edge and changes the address only after the strobe is up. This is how the hold behaviour is probed. Accesses that miss the window, and aborted accesses, are released by the bench's own timeout rather than by an acknowledge.

// File: rtl/ear_pkg.sv
package ear_pkg;

    // Control states of the bridge
    typedef enum logic [0:0] {
        EAR_IDLE   = 1'b0,
        EAR_ACCESS = 1'b1
    } ear_state_e;

endpackage

// File: rtl/ear_window_dec.sv
module ear_window_dec #(
    parameter int                ADDR_W    = 32,
    parameter int                OFF_W     = 5,
    parameter int                WORD_LSB  = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000
) (
    input  logic [ADDR_W-1:0] adr_i,
    output logic              hit_o,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int WIN_LSB = OFF_W + WORD_LSB;

    // Upper bits select the window, the word bits inside give the offset
    assign hit_o    = (adr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
    assign offset_o = adr_i[WIN_LSB-1:WORD_LSB];

endmodule

// File: rtl/ear_cycle_fsm.sv
module ear_cycle_fsm #(
    parameter bit IMM_ACK = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic hit_i,
    input  logic we_i,
    input  logic ext_ack_i,
    output logic capture_o,
    output logic rd_o,
    output logic wr_o,
    output logic ack_o
);
    import ear_pkg::*;

    ear_state_e state_q, state_d;
    logic       we_q;
    logic       done_src;

    // Acknowledge source chosen by parameter
    generate
        if (IMM_ACK) begin : g_imm_ack
            assign done_src = 1'b1;
        end else begin : g_relay_ack
            assign done_src = ext_ack_i;
        end
    endgenerate

    // State register and captured direction
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= EAR_IDLE;
            we_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture_o) begin
                we_q <= we_i;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EAR_IDLE: begin
                if (req_i && hit_i) begin
                    state_d = EAR_ACCESS;           // T_ACCEPT
                end                                 // else T_IGNORE / stay
            end
            EAR_ACCESS: begin
                if (!req_i) begin
                    state_d = EAR_IDLE;             // T_ABORT
                end else if (done_src) begin
                    state_d = EAR_IDLE;             // T_FINISH
                end                                 // else T_HOLD
            end
            default: state_d = EAR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        capture_o = 1'b0;
        rd_o      = 1'b0;
        wr_o      = 1'b0;
        ack_o     = 1'b0;
        unique case (state_q)
            EAR_IDLE: begin
                capture_o = req_i && hit_i;
            end
            EAR_ACCESS: begin
                rd_o  = req_i && !we_q;
                wr_o  = req_i && we_q;
                ack_o = req_i && done_src;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ear_datapath.sv
module ear_datapath #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] ext_rdata_i,
    output logic [OFF_W-1:0]  ext_adr_o,
    output logic [DATA_W-1:0] ext_wdata_o,
    output logic [DATA_W-1:0] host_rdata_o
);
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            off_q   <= '0;
            wdata_q <= '0;
        end else if (capture_i) begin
            off_q   <= offset_i;
            wdata_q <= wdata_i;
        end
    end

    // Buses carry values only while a strobe is active
    always_comb begin
        ext_adr_o    = (rd_i || wr_i) ? off_q : '0;
        ext_wdata_o  = wr_i ? wdata_q : '0;
        host_rdata_o = rd_i ? ext_rdata_i : '0;
    end

endmodule

// File: rtl/wb_ear_bridge.sv
module wb_ear_bridge #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                OFF_W     = 5,
    parameter int                WORD_LSB  = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000,
    parameter bit                IMM_ACK   = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [ADDR_W-1:0] wb_adr_i,
    input  logic [DATA_W-1:0] wb_dat_i,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic              wb_ack_o,
    output logic              ext_rd_o,
    output logic              ext_wr_o,
    output logic [OFF_W-1:0]  ext_adr_o,
    output logic [DATA_W-1:0] ext_dat_o,
    input  logic [DATA_W-1:0] ext_dat_i,
    input  logic              ext_ack_i
);
    logic             req;
    logic             hit;
    logic             capture;
    logic [OFF_W-1:0] offset;

    assign req = wb_cyc_i && wb_stb_i;

    ear_window_dec #(
        .ADDR_W   (ADDR_W),
        .OFF_W    (OFF_W),
        .WORD_LSB (WORD_LSB),
        .BASE_ADDR(BASE_ADDR)
    ) u_dec (
        .adr_i   (wb_adr_i),
        .hit_o   (hit),
        .offset_o(offset)
    );

    ear_cycle_fsm #(
        .IMM_ACK(IMM_ACK)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .req_i    (req),
        .hit_i    (hit),
        .we_i     (wb_we_i),
        .ext_ack_i(ext_ack_i),
        .capture_o(capture),
        .rd_o     (ext_rd_o),
        .wr_o     (ext_wr_o),
        .ack_o    (wb_ack_o)
    );

    ear_datapath #(
        .DATA_W(DATA_W),
        .OFF_W (OFF_W)
    ) u_dp (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .capture_i   (capture),
        .offset_i    (offset),
        .wdata_i     (wb_dat_i),
        .rd_i        (ext_rd_o),
        .wr_i        (ext_wr_o),
        .ext_rdata_i (ext_dat_i),
        .ext_adr_o   (ext_adr_o),
        .ext_wdata_o (ext_dat_o),
        .host_rdata_o(wb_dat_o)
    );

endmodule

// File: rtl/ear_bridge_checks.sv
module ear_bridge_checks #(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                OFF_W     = 5,
    parameter int                WORD_LSB  = 2,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000,
    parameter bit                IMM_ACK   = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wb_cyc_i,
    input logic              wb_stb_i,
    input logic [ADDR_W-1:0] wb_adr_i,
    input logic              wb_ack_o,
    input logic              ext_rd_o,
    input logic              ext_wr_o,
    input logic [OFF_W-1:0]  ext_adr_o,
    input logic [DATA_W-1:0] ext_dat_o,
    input logic              ext_ack_i
);
    localparam int WIN_LSB = OFF_W + WORD_LSB;

    logic strobe;
    logic in_win;
    assign strobe = ext_rd_o || ext_wr_o;
    assign in_win = (wb_adr_i[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);

    AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !strobe && !wb_ack_o); // R1
    AST_WINDOW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni) (strobe && !$past(strobe)) |-> $past(in_win)); // R2
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) !strobe |-> (ext_adr_o == '0) && (ext_dat_o == '0)); // R6
    AST_IMM_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (IMM_ACK && strobe) |=> !strobe); // R7
    AST_RELAY_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) wb_ack_o |-> strobe && (IMM_ACK || ext_ack_i)); // R8
    AST_HOLD_ADR: assert property (@(posedge clk_i) disable iff (!rst_ni) (strobe && !wb_ack_o) |=> (!strobe || $stable(ext_adr_o))); // R8
    AST_DROP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) wb_ack_o |=> !strobe); // R9
    AST_GATED_BY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) !(wb_cyc_i && wb_stb_i) |-> !strobe && !wb_ack_o); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ext_rd_o && ext_wr_o)); // R10

endmodule

bind wb_ear_bridge ear_bridge_checks #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFF_W    (OFF_W),
    .WORD_LSB (WORD_LSB),
    .BASE_ADDR(BASE_ADDR),
    .IMM_ACK  (IMM_ACK)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wb_cyc_i (wb_cyc_i),
    .wb_stb_i (wb_stb_i),
    .wb_adr_i (wb_adr_i),
    .wb_ack_o (wb_ack_o),
    .ext_rd_o (ext_rd_o),
    .ext_wr_o (ext_wr_o),
    .ext_adr_o(ext_adr_o),
    .ext_dat_o(ext_dat_o),
    .ext_ack_i(ext_ack_i)
);

// File: tb/test_wb_ear_bridge.sv
module test_wb_ear_bridge;

    localparam logic [31:0] BASE = 32'h0000_4000;
    localparam int          MAX_WAIT = 12;

    typedef struct {
        bit          ext;
        bit          wr;
        logic [4:0]  off;
        logic [31:0] data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_a = 1'b0, cyc_b = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] adr = '0, wdat = '0, ext_rdat = '0;
    logic        ext_ack = 1'b0;

    logic [31:0] dat_a, dat_b, edat_a, edat_b;
    logic [4:0]  eadr_a, eadr_b;
    logic        ack_a, ack_b, rd_a, rd_b, wr_a, wr_b;

    int   n_checks = 0;
    int   n_fail = 0;
    int   ack_delay = 1;
    int   resp_cnt = 0;
    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    // Immediate-acknowledge instance
    wb_ear_bridge #(.BASE_ADDR(BASE), .IMM_ACK(1'b1)) i_wb_ear_bridge (
        .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc_a), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_a), .wb_ack_o(ack_a),
        .ext_rd_o(rd_a), .ext_wr_o(wr_a), .ext_adr_o(eadr_a), .ext_dat_o(edat_a),
        .ext_dat_i(ext_rdat), .ext_ack_i(ext_ack)
    );

    // Relayed-acknowledge instance
    wb_ear_bridge #(.BASE_ADDR(BASE), .IMM_ACK(1'b0)) i_wb_ear_bridge_relay (
        .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc_b), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(dat_b), .wb_ack_o(ack_b),
        .ext_rd_o(rd_b), .ext_wr_o(wr_b), .ext_adr_o(eadr_b), .ext_dat_o(edat_b),
        .ext_dat_i(ext_rdat), .ext_ack_i(ext_ack)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Peripheral responder for the relayed instance
    always @(posedge clk) begin
        #2;
        if (rd_b || wr_b) begin
            resp_cnt++;
            ext_ack = (resp_cnt >= ack_delay);
        end else begin
            resp_cnt = 0;
            ext_ack  = 1'b0;
        end
    end

    // Monitor: pop the scoreboard whenever a host acknowledge is seen
    always @(negedge clk) begin
        if (rst_n && (ack_a || ack_b)) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R2", "unexpected acknowledge", {31'b0, ack_a || ack_b}, 32'h0);
            end else begin
                exp_t e;
                logic        s_rd, s_wr;
                logic [4:0]  s_adr;
                logic [31:0] s_edat, s_dat;
                e = sb_q.pop_front();
                s_rd   = e.ext ? rd_b   : rd_a;
                s_wr   = e.ext ? wr_b   : wr_a;
                s_adr  = e.ext ? eadr_b : eadr_a;
                s_edat = e.ext ? edat_b : edat_a;
                s_dat  = e.ext ? dat_b  : dat_a;
                check(!(rd_a && wr_a) && !(rd_b && wr_b), "R10", "both strobes", {31'b0, s_rd && s_wr}, 32'h0);
                check(s_adr == e.off, "R5", "offset", {27'b0, s_adr}, {27'b0, e.off});
                if (e.wr) begin
                    check(s_wr && !s_rd, "R4", "write strobe", {31'b0, s_wr}, 32'h1);
                    check(s_edat == e.data, "R4", "write data", s_edat, e.data);
                end else begin
                    check(s_rd && !s_wr, "R3", "read strobe", {31'b0, s_rd}, 32'h1);
                    check(s_dat == e.data, "R3", "read data", s_dat, e.data);
                end
            end
        end
    end

    // Driver: one host access, expected item pushed into the scoreboard
    task automatic access(input bit to_ext, input bit wr, input logic [31:0] a,
                          input logic [31:0] d, input int delay, input bit hit,
                          input bit perturb);
        int  waited = 0;
        bit  got = 0;
        bit  any_strobe = 0;
        int  exp_wait;
        exp_t e;
        ack_delay = delay;
        ext_rdat  = wr ? 32'hDEAD_0000 : d;
        if (hit) begin
            e.ext = to_ext; e.wr = wr; e.off = a[6:2]; e.data = d;
            sb_q.push_back(e);
        end
        @(posedge clk); #1;
        if (to_ext) cyc_b = 1'b1; else cyc_a = 1'b1;
        stb = 1'b1; we = wr; adr = a; wdat = wr ? d : 32'h5555_AAAA;
        while (!got && waited < MAX_WAIT && (hit || waited < 6)) begin
            @(negedge clk);
            waited++;
            any_strobe = any_strobe | rd_a | wr_a | rd_b | wr_b;
            got = to_ext ? ack_b : ack_a;
            if (perturb && waited == 2) begin
                adr  = a ^ 32'h0000_0F7C;
                wdat = ~wdat;
            end
        end
        @(posedge clk); #1;
        cyc_a = 1'b0; cyc_b = 1'b0; stb = 1'b0; we = 1'b0;
        exp_wait = to_ext ? delay + 1 : 2;
        if (hit) begin
            check(got == 1'b1, to_ext ? "R8" : "R7", "acknowledge seen", {31'b0, got}, 32'h1);
            check(waited == exp_wait, to_ext ? "R8" : "R7", "cycles to acknowledge", waited, exp_wait);
        end else begin
            check(!got && !any_strobe, "R2", "outside window activity", {30'b0, got, any_strobe}, 32'h0);
        end
        @(negedge clk);
        check(!rd_a && !wr_a && !rd_b && !wr_b, "R9", "strobes after end",
              {28'b0, rd_a, wr_a, rd_b, wr_b}, 32'h0);
        check(eadr_a == 0 && eadr_b == 0 && edat_a == 0 && edat_b == 0, "R6", "idle buses",
              edat_a | edat_b | {27'b0, eadr_a | eadr_b}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        check(1'b0, "WDOG", "watchdog expired", 32'h1, 32'h0);
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check(!ack_a && !rd_a && !wr_a && !ack_b && !rd_b && !wr_b, "R1", "control in reset",
              {26'b0, ack_a, rd_a, wr_a, ack_b, rd_b, wr_b}, 32'h0);
        check(dat_a == 0 && eadr_a == 0 && edat_a == 0 && dat_b == 0, "R1", "buses in reset",
              dat_a | edat_a | dat_b, 32'h0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(!ack_a && !rd_a && !wr_a && dat_a == 0, "R1", "idle after release",
              {29'b0, ack_a, rd_a, wr_a}, 32'h0);

        // Immediate mode: write, read, window edges (R3 R4 R5 R7)
        access(0, 1, BASE + 32'h14, 32'hCAFE_0001, 1, 1, 0);
        access(0, 0, BASE + 32'h14, 32'h1234_5678, 1, 1, 0);
        access(0, 1, BASE + 32'h7C, 32'hA5A5_5A5A, 1, 1, 0);
        access(0, 0, BASE, 32'h0BAD_F00D, 1, 1, 0);
        // Back-to-back style sequence of writes
        for (int i = 0; i < 4; i++) begin
            access(0, 1, BASE + 32'(i * 8), 32'h1000_0000 + 32'(i), 1, 1, 0);
        end

        // R2: misses on both sides of the window
        access(0, 1, BASE - 32'h4, 32'h1111_1111, 1, 0, 0);
        access(0, 0, BASE + 32'h80, 32'h2222_2222, 1, 0, 0);
        access(1, 1, 32'h8000_4000, 32'h3333_3333, 1, 0, 0);

        // Relayed mode with stretched cycles and bus perturbation (R8)
        access(1, 1, BASE + 32'h40, 32'hFEED_BEEF, 3, 1, 1);
        access(1, 0, BASE + 32'h08, 32'h7777_8888, 1, 1, 0);
        access(1, 0, BASE + 32'h7C, 32'h9999_AAAA, 4, 1, 1);

        // R9: abandoned access without acknowledge
        ack_delay = 100;
        @(posedge clk); #1;
        cyc_b = 1'b1; stb = 1'b1; we = 1'b0; adr = BASE + 32'h10;
        repeat (3) @(negedge clk);
        check(rd_b && !ack_b, "R8", "waiting on peripheral", {30'b0, rd_b, ack_b}, 32'h2);
        @(posedge clk); #1; stb = 1'b0;
        @(negedge clk);
        check(!rd_b && !ack_b, "R9", "strobe on drop", {30'b0, rd_b, ack_b}, 32'h0);
        @(posedge clk); #1; cyc_b = 1'b0;
        repeat (2) @(negedge clk);
        check(!rd_b && !wr_b && !ack_b, "R9", "quiet after abort", {29'b0, rd_b, wr_b, ack_b}, 32'h0);
        access(1, 1, BASE + 32'h20, 32'h0F0F_F0F0, 2, 1, 0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R7", "scoreboard drained", sb_q.size(), 32'h0);
        finish_up();
    end

endmodule